// File: doc/BRIEF.md
# DSP Accumulator Register File

This block holds the programmer-visible data and addressing registers of a 16-bit DSP core. It contains two 40-bit accumulators, each stored as three 16-bit fields (top, middle, bottom), two 32-bit auxiliary registers, each a pair of 16-bit words, four pointer, four step and four modulo registers, and one control and one status word. Software-style access goes through a 16-bit read port and a 16-bit write port, both addressed by a 5-bit register index. The arithmetic datapath uses a separate 40-bit accumulator read and write port, and a 32-bit auxiliary read port.

The block enforces the width rules of the accumulators. The top field carries only 8 significant bits and is always held sign-extended to 16 bits. When the status register selects 40-bit mode, a 16-bit write to a middle field loads the whole accumulator as a sign-extended 16-bit quantity. Reads are combinational. Writes land on the rising clock edge, and a synchronous reset clears everything.

Top module: `dspregs_file`

## Requirements
- R1: Register index map: 0-3 pointer, 4-7 step, 8-11 modulo, 12 control, 13 status, 14-15 accumulator top fields, 16-17 middle fields, 18-19 bottom fields, 20-21 auxiliary low words, 22-23 auxiliary high words (lane = index minus group base). A value written through the 16-bit port reads back unchanged at the same index, except where R2 and R3 apply.
- R2: A 16-bit write to an accumulator top field stores bits 7:0 of the value, sign-extended from bit 7 to 16 bits.
- R3: When status bit 14 (40-bit mode) is 1 before the edge, a 16-bit write to a middle field stores the value, sets the top field to 0xFFFF if value bit 15 is 1 and to 0x0000 otherwise, and clears the bottom field.
- R4: When status bit 14 is 0, a middle-field write changes only the middle field.
- R5: acc_rd_data is {top[7:0], middle, bottom} of the accumulator chosen by acc_rd_sel, which is the sign-extended top byte shifted left by 32, combined with middle shifted left by 16 and with bottom.
- R6: A 40-bit write stores bits 15:0 in the bottom field, bits 31:16 in the middle field and bits 39:32, sign-extended to 16 bits, in the top field.
- R7: aux_rd_data is the high word shifted left by 16, ORed with the low word of the auxiliary register chosen by aux_rd_sel.
- R8: When the 16-bit write port and the 40-bit port target the same accumulator in one cycle, the 16-bit write takes effect and the 40-bit write is dropped for that accumulator.
- R9: Reads are combinational: before the edge, a read of the index being written returns the old value; after the edge it returns the new one.
- R10: A synchronous reset, active high, clears every register to zero.
- R11: Indices 24-31 are unused. A read of one returns zero, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | 5 | Register index for the 16-bit read |
| rd_data | output | 16 | 16-bit read value |
| wr_en | input | 1 | 16-bit write enable |
| wr_idx | input | 5 | Register index for the 16-bit write |
| wr_data | input | 16 | 16-bit write value |
| acc_rd_sel | input | 1 | Accumulator selected for the 40-bit read |
| acc_rd_data | output | 40 | 40-bit accumulator value |
| acc_wr_en | input | 1 | 40-bit accumulator write enable |
| acc_wr_sel | input | 1 | Accumulator selected for the 40-bit write |
| acc_wr_data | input | 40 | 40-bit accumulator write value |
| aux_rd_sel | input | 1 | Auxiliary register selected for the 32-bit read |
| aux_rd_data | output | 32 | 32-bit auxiliary value |

## Verification
The bench builds the block with its default parameters: four lanes per addressing group, two accumulators, two auxiliary registers, a 5-bit index and the mode flag at status bit 14. With these values the whole index space, including the eight unused indices, can be swept exhaustively. Both accumulators can also be hit by the 16-bit and 40-bit ports in the same cycle, and the status mode flag can be toggled freely during randomized traffic, so the R3 and R4 paths and the R8 collision arise many times.

// File: rtl/dspregs_pkg.sv
package dspregs_pkg;

  localparam int WORD_W   = 16;
  localparam int TOP_SIG  = 8;
  localparam int ACC_W    = 2 * WORD_W + TOP_SIG;
  localparam int AUX_W    = 2 * WORD_W;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_PTR,
    RK_STEP,
    RK_MOD,
    RK_CTRL,
    RK_STAT,
    RK_ACC_TOP,
    RK_ACC_MID,
    RK_ACC_BOT,
    RK_AUX_LO,
    RK_AUX_HI
  } reg_kind_e;

  // Keep only the significant byte of a top field, sign-extended to a word.
  function automatic logic [WORD_W-1:0] top_extend(input logic [WORD_W-1:0] v);
    return {{(WORD_W-TOP_SIG){v[TOP_SIG-1]}}, v[TOP_SIG-1:0]};
  endfunction

  // 40-bit view of an accumulator built from its three fields.
  function automatic logic [ACC_W-1:0] acc_join(input logic [WORD_W-1:0] top,
                                                input logic [WORD_W-1:0] mid,
                                                input logic [WORD_W-1:0] bot);
    return {top[TOP_SIG-1:0], mid, bot};
  endfunction

  // Top field that a 40-bit write produces.
  function automatic logic [WORD_W-1:0] acc_top_of(input logic [ACC_W-1:0] v);
    return top_extend({{(WORD_W-TOP_SIG){1'b0}}, v[ACC_W-1:2*WORD_W]});
  endfunction

  function automatic logic [AUX_W-1:0] aux_join(input logic [WORD_W-1:0] hi,
                                                input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/dspregs_decode.sv
module dspregs_decode
  import dspregs_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int NUM_BANK = 4,
  parameter int NUM_ACC  = 2,
  parameter int NUM_AUX  = 2
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind,
  output logic [IDX_W-1:0] lane
);

  localparam int unsigned STEP_BASE = NUM_BANK;
  localparam int unsigned MOD_BASE  = 2 * NUM_BANK;
  localparam int unsigned CTRL_IDX  = 3 * NUM_BANK;
  localparam int unsigned STAT_IDX  = CTRL_IDX + 1;
  localparam int unsigned TOP_BASE  = STAT_IDX + 1;
  localparam int unsigned MID_BASE  = TOP_BASE + NUM_ACC;
  localparam int unsigned BOT_BASE  = MID_BASE + NUM_ACC;
  localparam int unsigned AXL_BASE  = BOT_BASE + NUM_ACC;
  localparam int unsigned AXH_BASE  = AXL_BASE + NUM_AUX;
  localparam int unsigned END_IDX   = AXH_BASE + NUM_AUX;

  int unsigned v;
  assign v = 32'(idx);

  always_comb begin
    kind = RK_NONE;
    lane = '0;
    if (v < STEP_BASE) begin
      kind = RK_PTR;     lane = IDX_W'(v);
    end else if (v < MOD_BASE) begin
      kind = RK_STEP;    lane = IDX_W'(v - STEP_BASE);
    end else if (v < CTRL_IDX) begin
      kind = RK_MOD;     lane = IDX_W'(v - MOD_BASE);
    end else if (v == CTRL_IDX) begin
      kind = RK_CTRL;
    end else if (v == STAT_IDX) begin
      kind = RK_STAT;
    end else if (v < MID_BASE) begin
      kind = RK_ACC_TOP; lane = IDX_W'(v - TOP_BASE);
    end else if (v < BOT_BASE) begin
      kind = RK_ACC_MID; lane = IDX_W'(v - MID_BASE);
    end else if (v < AXL_BASE) begin
      kind = RK_ACC_BOT; lane = IDX_W'(v - BOT_BASE);
    end else if (v < AXH_BASE) begin
      kind = RK_AUX_LO;  lane = IDX_W'(v - AXL_BASE);
    end else if (v < END_IDX) begin
      kind = RK_AUX_HI;  lane = IDX_W'(v - AXH_BASE);
    end
  end

endmodule

// File: rtl/dspregs_word_bank.sv
module dspregs_word_bank #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (we[g]) q[g] <= wdata;
    end
  end

endmodule

// File: rtl/dspregs_acc_lane.sv
module dspregs_acc_lane
  import dspregs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode40,
  input  logic              we_top,
  input  logic              we_mid,
  input  logic              we_bot,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wide_we,
  input  logic [ACC_W-1:0]  wide_data,
  output logic [WORD_W-1:0] top,
  output logic [WORD_W-1:0] mid,
  output logic [WORD_W-1:0] bot
);

  // The 16-bit port outranks the wide port; the caller already masks
  // wide_we on a collision, the ordering here keeps the lane safe alone.
  always_ff @(posedge clk) begin
    if (rst) begin
      top <= '0;
      mid <= '0;
      bot <= '0;
    end else if (we_top) begin
      top <= top_extend(wdata);
    end else if (we_mid) begin
      mid <= wdata;
      if (mode40) begin
        top <= {WORD_W{wdata[WORD_W-1]}};
        bot <= '0;
      end
    end else if (we_bot) begin
      bot <= wdata;
    end else if (wide_we) begin
      bot <= wide_data[WORD_W-1:0];
      mid <= wide_data[2*WORD_W-1:WORD_W];
      top <= acc_top_of(wide_data);
    end
  end

endmodule

// File: rtl/dspregs_file.sv
module dspregs_file
  import dspregs_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int NUM_BANK   = 4,
  parameter int NUM_ACC    = 2,
  parameter int NUM_AUX    = 2,
  parameter int MODE40_BIT = 14,
  localparam int ACC_SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int AUX_SEL_W = (NUM_AUX > 1) ? $clog2(NUM_AUX) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WORD_W-1:0]    rd_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [ACC_SEL_W-1:0] acc_rd_sel,
  output logic [ACC_W-1:0]     acc_rd_data,
  input  logic                 acc_wr_en,
  input  logic [ACC_SEL_W-1:0] acc_wr_sel,
  input  logic [ACC_W-1:0]     acc_wr_data,
  input  logic [AUX_SEL_W-1:0] aux_rd_sel,
  output logic [AUX_W-1:0]     aux_rd_data
);

  // ---------------- index decode ----------------
  reg_kind_e        rd_kind, wr_kind;
  logic [IDX_W-1:0] rd_lane, wr_lane;

  dspregs_decode #(.IDX_W(IDX_W), .NUM_BANK(NUM_BANK), .NUM_ACC(NUM_ACC), .NUM_AUX(NUM_AUX))
    u_rd_dec (.idx(rd_idx), .kind(rd_kind), .lane(rd_lane));
  dspregs_decode #(.IDX_W(IDX_W), .NUM_BANK(NUM_BANK), .NUM_ACC(NUM_ACC), .NUM_AUX(NUM_AUX))
    u_wr_dec (.idx(wr_idx), .kind(wr_kind), .lane(wr_lane));

  // Named events, also watched by the checker.
  logic wr_hits_top, wr_hits_mid, wr_hits_bot, rd_unused, wide_blocked, mode40;
  assign wr_hits_top = wr_en && (wr_kind == RK_ACC_TOP);
  assign wr_hits_mid = wr_en && (wr_kind == RK_ACC_MID);
  assign wr_hits_bot = wr_en && (wr_kind == RK_ACC_BOT);
  assign rd_unused   = (rd_kind == RK_NONE);

  // ---------------- write enables ----------------
  logic [NUM_BANK-1:0] ptr_we, step_we, mod_we;
  logic [1:0]          cs_we;
  logic [NUM_AUX-1:0]  axl_we, axh_we;
  logic [NUM_ACC-1:0]  top_we, mid_we, bot_we, wide_hit, wide_we;

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank_we
    assign ptr_we[g]  = wr_en && (wr_kind == RK_PTR)  && (wr_lane == IDX_W'(g));
    assign step_we[g] = wr_en && (wr_kind == RK_STEP) && (wr_lane == IDX_W'(g));
    assign mod_we[g]  = wr_en && (wr_kind == RK_MOD)  && (wr_lane == IDX_W'(g));
  end
  assign cs_we[0] = wr_en && (wr_kind == RK_CTRL);
  assign cs_we[1] = wr_en && (wr_kind == RK_STAT);

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux_we
    assign axl_we[g] = wr_en && (wr_kind == RK_AUX_LO) && (wr_lane == IDX_W'(g));
    assign axh_we[g] = wr_en && (wr_kind == RK_AUX_HI) && (wr_lane == IDX_W'(g));
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc_we
    assign top_we[g]   = wr_hits_top && (wr_lane == IDX_W'(g));
    assign mid_we[g]   = wr_hits_mid && (wr_lane == IDX_W'(g));
    assign bot_we[g]   = wr_hits_bot && (wr_lane == IDX_W'(g));
    assign wide_hit[g] = acc_wr_en && (acc_wr_sel == ACC_SEL_W'(g));
    assign wide_we[g]  = wide_hit[g] && !(top_we[g] || mid_we[g] || bot_we[g]);
  end
  assign wide_blocked = |(wide_hit & ~wide_we);

  // ---------------- storage ----------------
  logic [NUM_BANK-1:0][WORD_W-1:0] ptr_q, step_q, mod_q;
  logic [1:0][WORD_W-1:0]          cs_q;
  logic [NUM_AUX-1:0][WORD_W-1:0]  axl_q, axh_q;
  logic [NUM_ACC-1:0][WORD_W-1:0]  acc_top, acc_mid, acc_bot;

  dspregs_word_bank #(.N(NUM_BANK), .W(WORD_W)) u_ptr
    (.clk(clk), .rst(rst), .we(ptr_we),  .wdata(wr_data), .q(ptr_q));
  dspregs_word_bank #(.N(NUM_BANK), .W(WORD_W)) u_step
    (.clk(clk), .rst(rst), .we(step_we), .wdata(wr_data), .q(step_q));
  dspregs_word_bank #(.N(NUM_BANK), .W(WORD_W)) u_mod
    (.clk(clk), .rst(rst), .we(mod_we),  .wdata(wr_data), .q(mod_q));
  dspregs_word_bank #(.N(2), .W(WORD_W)) u_cs
    (.clk(clk), .rst(rst), .we(cs_we),   .wdata(wr_data), .q(cs_q));
  dspregs_word_bank #(.N(NUM_AUX), .W(WORD_W)) u_axl
    (.clk(clk), .rst(rst), .we(axl_we),  .wdata(wr_data), .q(axl_q));
  dspregs_word_bank #(.N(NUM_AUX), .W(WORD_W)) u_axh
    (.clk(clk), .rst(rst), .we(axh_we),  .wdata(wr_data), .q(axh_q));

  assign mode40 = cs_q[1][MODE40_BIT];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    dspregs_acc_lane u_lane (
      .clk(clk), .rst(rst), .mode40(mode40),
      .we_top(top_we[g]), .we_mid(mid_we[g]), .we_bot(bot_we[g]),
      .wdata(wr_data), .wide_we(wide_we[g]), .wide_data(acc_wr_data),
      .top(acc_top[g]), .mid(acc_mid[g]), .bot(acc_bot[g])
    );
  end

  // ---------------- read paths ----------------
  always_comb begin
    rd_data = '0;
    unique case (rd_kind)
      RK_CTRL: rd_data = cs_q[0];
      RK_STAT: rd_data = cs_q[1];
      default: begin
        for (int i = 0; i < NUM_BANK; i++) begin
          if (rd_lane == IDX_W'(i)) begin
            if (rd_kind == RK_PTR)  rd_data = ptr_q[i];
            if (rd_kind == RK_STEP) rd_data = step_q[i];
            if (rd_kind == RK_MOD)  rd_data = mod_q[i];
          end
        end
        for (int i = 0; i < NUM_ACC; i++) begin
          if (rd_lane == IDX_W'(i)) begin
            if (rd_kind == RK_ACC_TOP) rd_data = acc_top[i];
            if (rd_kind == RK_ACC_MID) rd_data = acc_mid[i];
            if (rd_kind == RK_ACC_BOT) rd_data = acc_bot[i];
          end
        end
        for (int i = 0; i < NUM_AUX; i++) begin
          if (rd_lane == IDX_W'(i)) begin
            if (rd_kind == RK_AUX_LO) rd_data = axl_q[i];
            if (rd_kind == RK_AUX_HI) rd_data = axh_q[i];
          end
        end
      end
    endcase
  end

  always_comb begin
    acc_rd_data = '0;
    for (int i = 0; i < NUM_ACC; i++)
      if (acc_rd_sel == ACC_SEL_W'(i))
        acc_rd_data = acc_join(acc_top[i], acc_mid[i], acc_bot[i]);
  end

  always_comb begin
    aux_rd_data = '0;
    for (int i = 0; i < NUM_AUX; i++)
      if (aux_rd_sel == AUX_SEL_W'(i))
        aux_rd_data = aux_join(axh_q[i], axl_q[i]);
  end

endmodule

// File: rtl/dspregs_file_chk.sv
module dspregs_file_chk
  import dspregs_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int NUM_ACC   = 2,
  parameter int ACC_SEL_W = 1
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            mode40,
  input logic [WORD_W-1:0]               wr_data,
  input logic                            wr_hits_top,
  input logic                            wr_hits_mid,
  input logic                            wr_hits_bot,
  input logic [IDX_W-1:0]                wr_lane,
  input logic                            rd_unused,
  input logic [WORD_W-1:0]               rd_data,
  input logic                            acc_wr_en,
  input logic [ACC_SEL_W-1:0]            acc_wr_sel,
  input logic [ACC_W-1:0]                acc_wr_data,
  input logic                            wide_blocked,
  input logic [NUM_ACC-1:0][WORD_W-1:0]  acc_top,
  input logic [NUM_ACC-1:0][WORD_W-1:0]  acc_mid,
  input logic [NUM_ACC-1:0][WORD_W-1:0]  acc_bot
);

  assert_unused_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_unused |-> rd_data == '0);

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_chk
    assert_top_write_sext_R2: assert property (@(posedge clk) disable iff (rst)
      wr_hits_top && wr_lane == IDX_W'(a) |=>
        acc_top[a] == {{8{$past(wr_data[7])}}, $past(wr_data[7:0])});

    assert_top_always_extended_R2: assert property (@(posedge clk) disable iff (rst)
      acc_top[a][15:8] == {8{acc_top[a][7]}});

    assert_mid_write_mode40_R3: assert property (@(posedge clk) disable iff (rst)
      wr_hits_mid && wr_lane == IDX_W'(a) && mode40 |=>
        acc_top[a] == {16{$past(wr_data[15])}} && acc_bot[a] == '0 &&
        acc_mid[a] == $past(wr_data));

    assert_mid_write_plain_R4: assert property (@(posedge clk) disable iff (rst)
      wr_hits_mid && wr_lane == IDX_W'(a) && !mode40 |=>
        acc_mid[a] == $past(wr_data) && acc_top[a] == $past(acc_top[a]) &&
        acc_bot[a] == $past(acc_bot[a]));

    assert_wide_write_split_R6: assert property (@(posedge clk) disable iff (rst)
      acc_wr_en && acc_wr_sel == ACC_SEL_W'(a) && !wide_blocked |=>
        acc_bot[a] == $past(acc_wr_data[15:0]) &&
        acc_mid[a] == $past(acc_wr_data[31:16]) &&
        acc_top[a] == {{8{$past(acc_wr_data[39])}}, $past(acc_wr_data[39:32])});

    assert_narrow_port_wins_R8: assert property (@(posedge clk) disable iff (rst)
      wr_hits_bot && wr_lane == IDX_W'(a) && acc_wr_en && acc_wr_sel == ACC_SEL_W'(a) |=>
        acc_bot[a] == $past(wr_data) && acc_mid[a] == $past(acc_mid[a]) &&
        acc_top[a] == $past(acc_top[a]));
  end

endmodule

bind dspregs_file dspregs_file_chk #(
  .IDX_W(IDX_W), .NUM_ACC(NUM_ACC), .ACC_SEL_W(ACC_SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .mode40(mode40), .wr_data(wr_data),
  .wr_hits_top(wr_hits_top), .wr_hits_mid(wr_hits_mid), .wr_hits_bot(wr_hits_bot),
  .wr_lane(wr_lane), .rd_unused(rd_unused), .rd_data(rd_data),
  .acc_wr_en(acc_wr_en), .acc_wr_sel(acc_wr_sel), .acc_wr_data(acc_wr_data),
  .wide_blocked(wide_blocked),
  .acc_top(acc_top), .acc_mid(acc_mid), .acc_bot(acc_bot)
);

// File: tb/dspregs_file_test.sv
module dspregs_file_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        acc_rd_sel = 1'b0;
  logic [39:0] acc_rd_data;
  logic        acc_wr_en = 1'b0;
  logic        acc_wr_sel = 1'b0;
  logic [39:0] acc_wr_data = '0;
  logic        aux_rd_sel = 1'b0;
  logic [31:0] aux_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dspregs_file uut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .acc_rd_sel(acc_rd_sel), .acc_rd_data(acc_rd_data),
    .acc_wr_en(acc_wr_en), .acc_wr_sel(acc_wr_sel), .acc_wr_data(acc_wr_data),
    .aux_rd_sel(aux_rd_sel), .aux_rd_data(aux_rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R10";

  // Reference model: one flat word per used index (R1 map).
  logic [15:0] mdl [NREG];

  function automatic logic [15:0] exp_rd(input int idx);
    return (idx < NREG) ? mdl[idx] : 16'h0;
  endfunction

  task automatic model_edge(bit r, bit we, int wi, logic [15:0] wd,
                            bit awe, int as, logic [39:0] ad);
    logic [15:0] nxt [NREG];
    bit m40, blk;
    if (r) begin
      foreach (mdl[i]) mdl[i] = 16'h0;
      return;
    end
    foreach (mdl[i]) nxt[i] = mdl[i];
    m40 = mdl[13][14];
    blk = we && (wi == 14 + as || wi == 16 + as || wi == 18 + as);
    if (awe && !blk) begin
      nxt[18 + as] = ad[15:0];
      nxt[16 + as] = ad[31:16];
      nxt[14 + as] = ad[39] ? {8'hFF, ad[39:32]} : {8'h00, ad[39:32]};
    end
    if (we && wi < NREG) begin
      if (wi == 14 || wi == 15) begin
        nxt[wi] = wd[7] ? {8'hFF, wd[7:0]} : {8'h00, wd[7:0]};
      end else begin
        nxt[wi] = wd;
        if ((wi == 16 || wi == 17) && m40) begin
          nxt[wi - 2] = wd[15] ? 16'hFFFF : 16'h0000;
          nxt[wi + 2] = 16'h0000;
        end
      end
    end
    foreach (mdl[i]) mdl[i] = nxt[i];
  endtask

  task automatic compare(string t);
    int s;
    logic [39:0] ea;
    logic [31:0] ex;
    s = int'(acc_rd_sel);
    ea = {mdl[14 + s][7:0], mdl[16 + s], mdl[18 + s]};
    ex = {mdl[22 + int'(aux_rd_sel)], mdl[20 + int'(aux_rd_sel)]};
    checks++;
    if (rd_data !== exp_rd(int'(rd_idx))) begin
      errors++;
      $display("FAIL %s rd_data idx %0d: actual %h expected %h", t, rd_idx, rd_data, exp_rd(int'(rd_idx)));
    end
    checks++;
    if (acc_rd_data !== ea) begin
      errors++;
      $display("FAIL R5 acc_rd_data sel %0d: actual %h expected %h", s, acc_rd_data, ea);
    end
    checks++;
    if (aux_rd_data !== ex) begin
      errors++;
      $display("FAIL R7 aux_rd_data sel %0d: actual %h expected %h", aux_rd_sel, aux_rd_data, ex);
    end
  endtask

  // One clock: drive at the falling edge, check old values (R9), then new.
  task automatic cyc(bit r, bit we, int wi, logic [15:0] wd, bit awe, int as,
                     logic [39:0] ad, int ri, int rs, int xs);
    rst = r; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    acc_wr_en = awe; acc_wr_sel = 1'(as); acc_wr_data = ad;
    rd_idx = 5'(ri); acc_rd_sel = 1'(rs); aux_rd_sel = 1'(xs);
    #1;
    if (!r) compare("R9");
    @(posedge clk);
    model_edge(r, we, wi, wd, awe, as, ad);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr16(int wi, logic [15:0] wd);
    cyc(0, 1, wi, wd, 0, 0, 40'h0, wi, 0, 0);
  endtask

  task automatic idle_read(int ri, int rs, int xs);
    cyc(0, 0, 0, 16'h0, 0, 0, 40'h0, ri, rs, xs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 16'hxxxx;
    @(negedge clk);
    // R10: reset clears everything
    tag = "R10";
    cyc(1, 0, 0, 16'h0, 0, 0, 40'h0, 0, 0, 0);
    cyc(1, 0, 0, 16'h0, 0, 0, 40'h0, 13, 1, 1);

    // R1: write every used index, read it back
    tag = "R1";
    for (int i = 0; i < NREG; i++) wr16(i, 16'(i * 16'h1111) ^ 16'h5A3C);
    for (int i = 0; i < 32; i++) idle_read(i, i % 2, (i / 2) % 2);

    // R2: top field keeps 8 significant bits
    tag = "R2";
    wr16(14, 16'h1280);
    wr16(15, 16'hAB7F);
    idle_read(14, 0, 0);

    // R3: 40-bit mode middle writes
    tag = "R3";
    wr16(13, 16'h4000);
    wr16(16, 16'h8001);
    wr16(17, 16'h7000);
    idle_read(14, 1, 0);
    idle_read(18, 0, 0);

    // R4: mode off, middle write alone
    tag = "R4";
    wr16(13, 16'hBFFF);
    wr16(18, 16'h1357);
    wr16(16, 16'hC0DE);
    idle_read(14, 0, 0);

    // R6: wide writes, both signs
    tag = "R6";
    cyc(0, 0, 0, 16'h0, 1, 0, 40'h80_1234_5678, 14, 0, 0);
    cyc(0, 0, 0, 16'h0, 1, 1, 40'h7F_FFFF_0000, 15, 1, 1);
    idle_read(16, 0, 0);

    // R8: both ports on one accumulator
    tag = "R8";
    cyc(0, 1, 18, 16'hAAAA, 1, 0, 40'h11_2222_3333, 18, 0, 0);
    cyc(0, 1, 15, 16'h00F0, 1, 1, 40'h01_4444_5555, 15, 1, 0);
    cyc(0, 1, 19, 16'h0BEE, 1, 0, 40'hFE_6666_7777, 19, 0, 0);
    idle_read(16, 0, 0);

    // R7: auxiliary pairs
    tag = "R7";
    wr16(20, 16'h1111); wr16(22, 16'h2222); wr16(21, 16'h3333); wr16(23, 16'h4444);
    idle_read(20, 0, 0);
    idle_read(21, 1, 1);

    // R11: unused indices ignore writes, read zero
    tag = "R11";
    for (int i = NREG; i < 32; i++) wr16(i, 16'hFFFF);
    for (int i = 0; i < 32; i++) idle_read(i, i % 2, i % 2);

    // R10: reset in the middle of traffic
    tag = "R10";
    cyc(1, 1, 5, 16'h1234, 1, 0, 40'hFF_FFFF_FFFF, 5, 0, 0);
    for (int i = 0; i < NREG; i++) idle_read(i, 1, 1);

    // R1/R3/R4/R8 mixed random traffic
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      int wi;
      logic [15:0] wd;
      wi = ($urandom_range(3) == 0) ? 13 : ($urandom_range(1) ? int'($urandom_range(14, 19))
                                                              : int'($urandom_range(31)));
      wd = 16'($urandom);
      cyc(0, $urandom_range(3) != 0, wi, wd, $urandom_range(1), $urandom_range(1),
          {8'($urandom), 32'($urandom)}, $urandom_range(31), $urandom_range(1),
          $urandom_range(1));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule